// File: doc/BRIEF.md
# Programmable Even-Ratio Clock Prescaler

This block produces the processor clock by dividing a fast reference clock from the PLL by an even ratio that software picks. A 4-bit code held in a memory-mapped control word selects the ratio. The output runs at the reference frequency divided by twice the code, so codes 1 to 15 give ratios from 2 to 30. Every phase of the output lasts exactly `code` reference cycles, which gives a 50% duty cycle for every legal code. After reset the code is 15.

Software reaches the block through a simple synchronous register port. A write is taken on a reference clock edge while the write strobe is high, and read data follows the address combinationally. A new code does not apply at once. It is held until the next rising edge of the output, so a change can never shorten a phase. Code zero has no meaning: the block refuses it, keeps the current ratio and sets a sticky flag. The block also compares the running code with the code for the companion bus clock and flags any setting that would make the processor clock slower than the bus clock.

The reset input is asynchronous and active low. It is released through a two-stage synchronizer, so the registers leave reset two reference edges after the input rises.

Top module: `cpu_clk_prescaler`

## Requirements
- R1: Reset state: the ratio code reads back as 15, `clk_cpu` is low, both flags are low, and the first full output period is 30 reference cycles.
- R2: The ratio code is bits 3:0 of the control word at offset 0x1C. A write there with a nonzero code stores it, and a read returns it.
- R3: Bits 31:4 of the control word always read as 0. Their value in a write has no effect on the stored code.
- R4: With code N in force, each high phase and each low phase of `clk_cpu` lasts exactly N reference cycles, so the period is 2×N.
- R5: A write of code 0 to the control word is ignored. The stored code and the running ratio stay unchanged.
- R6: A write of code 0 sets `illegal_code_seen`, which also reads as bit 0 of the status word at offset 0x20. The flag stays set until reset.
- R7: A newly written code takes effect only at the next rising edge of `clk_cpu`. A high phase and the low phase after it are therefore always the same length, and the phase in progress is never cut short.
- R8: `clk_order_violation` is high exactly when the code in force is greater, as an unsigned number, than `bus_ratio_code`.
- R9: Reads from any address other than 0x1C and 0x20 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Reference clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, sampled on `clk_pll` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| bus_ratio_code | input | 4 | Ratio code of the companion bus clock |
| clk_cpu | output | 1 | Divided processor clock |
| illegal_code_seen | output | 1 | Sticky flag: a zero code was written |
| clk_order_violation | output | 1 | Processor ratio code exceeds the bus ratio code |

## Verification
The bench builds the block with its default parameters: a 4-bit code, a reset code of 15, the control word at 0x1C and the status word at 0x20. With a 4-bit code the whole code space is small enough to sweep. Every legal ratio from 2 to 30 is measured period by period, and the zero code and the reset code can both be exercised directly. A behavioural model built on a phase countdown is compared with the outputs on every cycle. Ratio changes are also written at arbitrary points inside a phase, and a duty monitor checks every high and low phase pair.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  localparam int unsigned RATIO_CODE_W = 4;
  typedef logic [RATIO_CODE_W-1:0] ratio_code_t;
endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned RESET_CODE  = 15,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [CODE_W-1:0] wr_code,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] code_req,
  output logic              illegal_seen
);
  localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] req_q, req_d;
  logic              err_q, err_d;
  logic              ctrl_wr, zero_code;

  assign ctrl_wr   = wr && (addr == CTRL_OFFSET);
  assign zero_code = (wr_code == '0);

  always_comb begin
    req_d = req_q;
    err_d = err_q;
    if (ctrl_wr) begin
      if (zero_code) err_d = 1'b1;
      else           req_d = wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= CODE_RST;
      err_q <= 1'b0;
    end else begin
      req_q <= req_d;
      err_q <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_OFFSET)      rdata[CODE_W-1:0] = req_q;
    else if (addr == STAT_OFFSET) rdata[0]          = err_q;
  end

  assign code_req     = req_q;
  assign illegal_seen = err_q;

  a_r5_zero_write_keeps_code: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && zero_code) |=> $stable(req_q));
  a_r5_code_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req_q != '0);
  a_r6_zero_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && zero_code) |=> err_q);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/cpuclk_divider.sv
module cpuclk_divider #(
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned RESET_CODE = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_req,
  output logic              clk_div,
  output logic [CODE_W-1:0] code_act
);
  localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(RESET_CODE);

  logic [CODE_W-1:0] cnt_q, cnt_d;
  logic [CODE_W-1:0] act_q, act_d;
  logic              out_q, out_d;
  logic              phase_end, rise_next;

  assign phase_end = (cnt_q == (act_q - 1'b1));
  assign rise_next = phase_end && !out_q;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    out_d = out_q;
    act_d = act_q;
    if (phase_end) begin
      cnt_d = '0;
      out_d = ~out_q;
    end
    if (rise_next) act_d = code_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
      act_q <= CODE_RST;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
      act_q <= act_d;
    end
  end

  assign clk_div  = out_q;
  assign code_act = act_q;

  a_r4_count_within_phase: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);
  a_r7_ratio_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $rose(out_q));
  a_r4_phase_start_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> (cnt_q == '0));
endmodule

// File: rtl/cpuclk_guard.sv
module cpuclk_guard #(
  parameter int unsigned CODE_W = 4
) (
  input  logic [CODE_W-1:0] cpu_code,
  input  logic [CODE_W-1:0] bus_code,
  output logic              too_slow
);
  assign too_slow = (cpu_code > bus_code);
endmodule

// File: rtl/cpu_clk_prescaler.sv
module cpu_clk_prescaler #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CODE_W      = cpuclk_pkg::RATIO_CODE_W,
  parameter int unsigned RESET_CODE  = 15,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFFSET = 8'h20
) (
  input  logic              clk_pll,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [CODE_W-1:0] bus_ratio_code,
  output logic              clk_cpu,
  output logic              illegal_code_seen,
  output logic              clk_order_violation
);
  logic              sync1_q, sync2_q;
  logic [CODE_W-1:0] code_req, code_act;
  logic              unused_wdata_hi;

  always_ff @(posedge clk_pll or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:CODE_W];

  cpuclk_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .RESET_CODE(RESET_CODE),
    .CTRL_OFFSET(CTRL_OFFSET), .STAT_OFFSET(STAT_OFFSET)
  ) u_regs (
    .clk(clk_pll), .rst_n(sync2_q), .addr(reg_addr), .wr(reg_wr),
    .wr_code(reg_wdata[CODE_W-1:0]), .rdata(reg_rdata),
    .code_req(code_req), .illegal_seen(illegal_code_seen)
  );

  cpuclk_divider #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_div (
    .clk(clk_pll), .rst_n(sync2_q), .code_req(code_req),
    .clk_div(clk_cpu), .code_act(code_act)
  );

  cpuclk_guard #(.CODE_W(CODE_W)) u_guard (
    .cpu_code(code_act), .bus_code(bus_ratio_code), .too_slow(clk_order_violation)
  );

  a_r3_upper_bits_zero: assert property (@(posedge clk_pll) disable iff (!sync2_q)
    reg_rdata[DATA_W-1:CODE_W] == '0);
  a_r8_violation_tracks_codes: assert property (@(posedge clk_pll) disable iff (!sync2_q)
    (clk_order_violation && $stable(code_act)) |-> (code_act != '0));
endmodule

// File: tb/cpu_clk_prescaler_test.sv
module cpu_clk_prescaler_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  bus_ratio_code;
  logic        clk_cpu, illegal_code_seen, clk_order_violation;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cpu_clk_prescaler uut (
    .clk_pll(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_ratio_code(bus_ratio_code),
    .clk_cpu(clk_cpu), .illegal_code_seen(illegal_code_seen),
    .clk_order_violation(clk_order_violation)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural model: phase countdown
  int m_req, m_act, m_left, m_err, old_req;
  bit m_out, m_s1, m_s2, old_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_req = 15; m_act = 15; m_left = 15; m_out = 0; m_err = 0;
    end else begin
      if (m_s2) begin
        old_req = m_req;
        old_out = m_out;
        if (reg_wr && reg_addr == 8'h1C) begin
          if (reg_wdata[3:0] != 0) m_req = int'(reg_wdata[3:0]);
          else m_err = 1;
        end
        m_left--;
        if (m_left == 0) begin
          m_out = !old_out;
          if (!old_out) m_act = old_req;
          m_left = m_act;
        end
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
  end

  function automatic int exp_rdata();
    if (reg_addr == 8'h1C) return m_req;
    if (reg_addr == 8'h20) return m_err;
    return 0;
  endfunction

  // per-cycle comparison with the model
  always @(negedge clk) if (!done) begin
    chk(clk_cpu === m_out, "R4/R7", "clk_cpu vs model", longint'(clk_cpu), longint'(m_out));
    chk(reg_rdata === 32'(exp_rdata()), "R2/R9", "rdata vs model", longint'(reg_rdata), exp_rdata());
    chk(illegal_code_seen === m_err[0], "R6", "illegal flag vs model", longint'(illegal_code_seen), m_err);
    chk(clk_order_violation === (m_act > int'(bus_ratio_code)), "R8", "violation vs model",
        longint'(clk_order_violation), longint'(m_act > int'(bus_ratio_code)));
  end

  // duty monitor: high phase must equal the following low phase (R7)
  int run_len = 0, last_high = 0;
  bit have_high = 0, prev_lvl = 0;
  always @(negedge clk) begin
    if (!rst_n || !m_s2) begin
      have_high = 0; run_len = 0; prev_lvl = clk_cpu;
    end else begin
      if (clk_cpu == prev_lvl) run_len++;
      else begin
        if (clk_cpu) begin
          if (have_high) chk(run_len == last_high, "R7", "low phase vs preceding high", run_len, last_high);
        end else begin
          last_high = run_len; have_high = 1;
        end
        run_len = 1;
      end
      prev_lvl = clk_cpu;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input int exp, input string req);
    step(); reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == 32'(exp), req, "register read", longint'(reg_rdata), exp);
  endtask

  task automatic wait_rise();
    bit p;
    do begin p = clk_cpu; @(negedge clk); end while (!(!p && clk_cpu));
  endtask

  task automatic measure(output int n);
    bit p;
    wait_rise();
    n = 0;
    do begin p = clk_cpu; @(negedge clk); n++; end while (!(!p && clk_cpu));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      chk(1'b0, "ALL", "watchdog expired", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 0; reg_addr = 8'h1C; reg_wr = 0; reg_wdata = 0; bus_ratio_code = 4'd15;
    repeat (3) step();
    rst_n = 1;
    repeat (4) step();
    @(negedge clk);
    // R1 reset state
    chk(clk_cpu == 1'b0, "R1", "clk_cpu after reset", clk_cpu, 0);
    chk(reg_rdata == 32'd15, "R1", "code after reset", reg_rdata, 15);
    chk(illegal_code_seen == 1'b0, "R1", "illegal flag after reset", illegal_code_seen, 0);
    chk(clk_order_violation == 1'b0, "R1", "violation after reset", clk_order_violation, 0);
    measure(n);
    chk(n == 30, "R1", "reset period", n, 30);

    // R4 / R2 sweep of every legal code
    for (int c = 1; c <= 15; c++) begin
      wr(8'h1C, 32'(c));
      wait_rise(); wait_rise();
      measure(n);
      chk(n == 2 * c, "R4", "period for code", n, 2 * c);
      rd_chk(8'h1C, c, "R2");
    end

    // R3 reserved bits
    wr(8'h1C, 32'hABCD_EF05);
    rd_chk(8'h1C, 5, "R3");

    // R5 / R6 zero code
    wr(8'h1C, 32'h0000_0000);
    rd_chk(8'h1C, 5, "R5");
    chk(illegal_code_seen == 1'b1, "R6", "illegal flag port", illegal_code_seen, 1);
    rd_chk(8'h20, 1, "R6");
    wait_rise(); wait_rise();
    measure(n);
    chk(n == 10, "R5", "period after zero write", n, 10);
    wr(8'h1C, 32'h0000_0007);
    rd_chk(8'h20, 1, "R6");

    // R9 unmapped address
    wr(8'h40, 32'h0000_0003);
    rd_chk(8'h40, 0, "R9");
    rd_chk(8'h1C, 7, "R9");
    wait_rise(); wait_rise();

    // R8 ordering against bus code (code 7 in force)
    step(); bus_ratio_code = 4'd6;
    @(negedge clk);
    chk(clk_order_violation == 1'b1, "R8", "cpu 7 vs bus 6", clk_order_violation, 1);
    step(); bus_ratio_code = 4'd7;
    @(negedge clk);
    chk(clk_order_violation == 1'b0, "R8", "cpu 7 vs bus 7", clk_order_violation, 0);
    step(); bus_ratio_code = 4'd9;
    @(negedge clk);
    chk(clk_order_violation == 1'b0, "R8", "cpu 7 vs bus 9", clk_order_violation, 0);

    // R7 changes written at arbitrary points inside phases
    for (int k = 0; k < 24; k++) begin
      wr(8'h1C, 32'(((k * 7) % 15) + 1));
      repeat ((k * 5) % 23) step();
    end
    wr(8'h1C, 32'd1);
    repeat (2) step();
    wr(8'h1C, 32'd15);
    repeat (100) step();

    // R6 flag cleared only by reset
    step(); rst_n = 0;
    step(); rst_n = 1;
    repeat (4) step();
    @(negedge clk);
    chk(illegal_code_seen == 1'b0, "R6", "flag after second reset", illegal_code_seen, 0);
    chk(reg_rdata == 32'd15, "R1", "code after second reset", reg_rdata, 15);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule